// File: doc/BRIEF.md
# SPI Clock-Chip Register Target

This block is the serial front end of a real-time clock. A host reaches the clock's register space over a four-wire SPI link with an active-high select. Every transaction begins with an address byte. Bit 7 of that byte selects the direction and the low seven bits give the first register. Each data byte that follows moves the register pointer forward by one, so one select period can move a whole burst of bytes. The serial pins are oversampled in the system clock domain. The SPI clock half period must therefore last at least eight system clock cycles.

The block holds the control byte, the two alarm flags, the trickle-charge setting and 96 bytes of scratch RAM. The seconds-to-year and alarm comparison bytes belong to the timekeeping logic. The block reaches them through single-cycle read and write strobes. That side has no back-pressure: the timekeeping logic must accept each write strobe, and present read data combinationally, in the cycle the strobe is high.

A write-protect bit in the control byte blocks every write except a write to control itself. Reading an alarm's comparison bytes acknowledges that alarm's flag.

Top module: `rtc_spi_regif`

## Requirements
- R1: After reset the control byte is 0xC0 (oscillator off, write protect on, alarm interrupts off), both alarm flags are 0, the trickle byte is 0x00 and the MISO enable is low.
- R2: The link uses mode CPOL=0/CPHA=1 with an active-high select. MOSI is sampled on the falling SCLK edge and MISO changes after the rising edge, MSB first, 8 bits per byte. The first byte is the address: bit 7 = 1 means write, bit 7 = 0 means read, and bits 6:0 are the start register.
- R3: The register pointer goes up by one after every data byte while select stays high, and wraps from 0x7F to 0x00.
- R4: Addresses 0x00–0x0E belong to the timekeeping logic. A write gives one reg_wr_stb cycle carrying reg_addr and reg_wdata. A read gives one reg_rd_stb cycle in which reg_rdata is captured. A read fetches the byte at the next address as soon as the previous byte has been shifted in, and also fetches the byte after the last byte clocked.
- R5: Control (0x0F) fields: bit 7 oscillator off, bit 6 write protect, bit 2 interrupt pin mode, bit 1 alarm-1 interrupt enable, bit 0 alarm-0 interrupt enable. Bits 5:3 always read 0.
- R6: While control bit 6 is set, a write to any address other than 0x0F has no effect. No reg_wr_stb is issued and no local byte changes.
- R7: Status (0x10) holds the alarm-0 flag in bit 0 and the alarm-1 flag in bit 1, and bits 7:2 read 0. A pulse on alm_hit[i] sets flag i. Writes to status are ignored.
- R8: A read fetch at 0x07–0x0A clears the alarm-0 flag, and one at 0x0B–0x0E clears the alarm-1 flag. If alm_hit for that alarm arrives in the same cycle, the flag stays set.
- R9: The trickle byte (0x11) and scratch RAM (0x20–0x7F) can be read and written. Addresses 0x12–0x1F read 0x00 and ignore writes.
- R10: If select drops in the middle of a byte, that partial byte is discarded. MISO is enabled only while select is high and the data phase of a read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, idle low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for MISO |
| reg_rd_stb | output | 1 | Read strobe to timekeeping logic |
| reg_wr_stb | output | 1 | Write strobe to timekeeping logic |
| reg_addr | output | 4 | Timekeeping register index (0x0–0xE) |
| reg_wdata | output | 8 | Write data for timekeeping logic |
| reg_rdata | input | 8 | Read data from timekeeping logic, valid in the strobe cycle |
| alm_hit | input | 2 | One-cycle alarm match pulses, bit i for alarm i |
| alm_flag | output | 2 | Alarm flags as held in status |
| ctl_osc_off | output | 1 | Control bit 7 |
| ctl_int_mode | output | 1 | Control bit 2 |
| ctl_alm_ie | output | 2 | Control bits 1:0 |
| trickle_cfg | output | 8 | Trickle-charge setting byte |

## Verification
An alarm match and the read fetch that acknowledges that same alarm can land on the same clock edge. The bench provokes this by watching for the read strobe at an alarm-1 address and then raising alm_hit[1] for exactly that cycle. The select is dropped after the address byte, so no further fetch follows. The collision is judged correct if the alarm-1 flag is still set afterwards. The same sequence run without the hit pulse must leave the flag clear.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
  localparam int AW = 7;
  localparam int DW = 8;

  localparam logic [AW-1:0] A_ALM0_LO = 7'h07;
  localparam logic [AW-1:0] A_ALM1_LO = 7'h0B;
  localparam logic [AW-1:0] A_EXT_HI  = 7'h0E;
  localparam logic [AW-1:0] A_CTRL    = 7'h0F;
  localparam logic [AW-1:0] A_STAT    = 7'h10;
  localparam logic [AW-1:0] A_TRKL    = 7'h11;
  localparam logic [AW-1:0] A_RAM_LO  = 7'h20;

  localparam logic [DW-1:0] CTRL_RST  = 8'hC0;
  localparam logic [DW-1:0] CTRL_KEEP = 8'hC7;
  localparam int BIT_OSC  = 7;
  localparam int BIT_WP   = 6;
  localparam int BIT_MODE = 2;

  typedef enum logic [2:0] {
    RG_EXT, RG_CTRL, RG_STAT, RG_TRKL, RG_RAM, RG_HOLE
  } region_e;

  function automatic region_e region_of(input logic [AW-1:0] a);
    if (a <= A_EXT_HI)       return RG_EXT;
    else if (a == A_CTRL)    return RG_CTRL;
    else if (a == A_STAT)    return RG_STAT;
    else if (a == A_TRKL)    return RG_TRKL;
    else if (a >= A_RAM_LO)  return RG_RAM;
    else                     return RG_HOLE;
  endfunction

  function automatic logic [1:0] alarm_sel(input logic [AW-1:0] a);
    logic [1:0] s;
    s[0] = (a >= A_ALM0_LO) && (a < A_ALM1_LO);
    s[1] = (a >= A_ALM1_LO) && (a <= A_EXT_HI);
    return s;
  endfunction
endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dprev
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else if (s == 0) stg[s] <= din;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dprev <= '0;
    else dprev <= stg[STAGES-1];
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/rtc_spi_shifter.sv
module rtc_spi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          mosi_bit,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_data,
  output logic [DW-1:0] rx_byte,
  output logic          byte_done,
  output logic          tx_bit
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW-1);

  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] rx_q, tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_q      <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
      end else if (sclk_fall) begin
        rx_q      <= {rx_q[DW-2:0], mosi_bit};
        bit_cnt   <= bit_cnt + 1'b1;
        byte_done <= (bit_cnt == LAST);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else if (tx_load) tx_q <= tx_data;
    else if (cs_act && sclk_rise && bit_cnt != '0) tx_q <= {tx_q[DW-2:0], 1'b0};
  end

  assign rx_byte = rx_q;
  assign tx_bit  = tx_q[DW-1];

  // R2
  byte_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (bit_cnt == '0));
endmodule

// File: rtl/rtc_spi_regfile.sv
module rtc_spi_regfile
  import rtc_spi_pkg::*;
#(
  parameter logic [AW-1:0] RAM_BASE = A_RAM_LO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_go,
  input  logic          rd_go,
  output logic [DW-1:0] rd_data,
  output logic          reg_rd_stb,
  output logic          reg_wr_stb,
  output logic [3:0]    reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  input  logic [1:0]    alm_hit,
  output logic [1:0]    alm_flag,
  output logic          ctl_osc_off,
  output logic          ctl_int_mode,
  output logic [1:0]    ctl_alm_ie,
  output logic [DW-1:0] trickle_cfg
);
  localparam int RAM_DEPTH = (2**AW) - int'(RAM_BASE);
  localparam int IW = $clog2(RAM_DEPTH);

  logic [DW-1:0] ctrl_q, trkl_q;
  logic [DW-1:0] ram [RAM_DEPTH];
  logic [1:0]    flag_q;
  logic [1:0]    asel;
  logic [IW-1:0] ram_idx;
  logic          wp, wr_ok;
  region_e       rg;

  assign rg      = region_of(addr);
  assign asel    = alarm_sel(addr);
  assign wp      = ctrl_q[BIT_WP];
  assign wr_ok   = wr_go && (!wp || rg == RG_CTRL);
  assign ram_idx = IW'(addr - RAM_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      trkl_q <= '0;
    end else if (wr_ok) begin
      if (rg == RG_CTRL) ctrl_q <= wdata & CTRL_KEEP;
      if (rg == RG_TRKL) trkl_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && rg == RG_RAM) ram[ram_idx] <= wdata;
  end

  for (genvar i = 0; i < 2; i++) begin : g_alarm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else if (alm_hit[i]) flag_q[i] <= 1'b1;
      else if (rd_go && asel[i]) flag_q[i] <= 1'b0;
    end

    // R8
    hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alm_hit[i] |=> flag_q[i]);

    // R8
    read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && asel[i] && !alm_hit[i]) |=> !flag_q[i]);
  end

  always_comb begin
    unique case (rg)
      RG_EXT:  rd_data = reg_rdata;
      RG_CTRL: rd_data = ctrl_q;
      RG_STAT: rd_data = {6'b0, flag_q};
      RG_TRKL: rd_data = trkl_q;
      RG_RAM:  rd_data = ram[ram_idx];
      default: rd_data = '0;
    endcase
  end

  assign reg_wr_stb   = wr_ok && rg == RG_EXT;
  assign reg_rd_stb   = rd_go && rg == RG_EXT;
  assign reg_addr     = addr[3:0];
  assign reg_wdata    = wdata;
  assign alm_flag     = flag_q;
  assign ctl_osc_off  = ctrl_q[BIT_OSC];
  assign ctl_int_mode = ctrl_q[BIT_MODE];
  assign ctl_alm_ie   = ctrl_q[1:0];
  assign trickle_cfg  = trkl_q;

  // R6
  wp_trickle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wp && rg == RG_TRKL) |=> $stable(trkl_q));
endmodule

// File: rtl/rtc_spi_regif.sv
module rtc_spi_regif
  import rtc_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  output logic          reg_rd_stb,
  output logic          reg_wr_stb,
  output logic [3:0]    reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  input  logic [1:0]    alm_hit,
  output logic [1:0]    alm_flag,
  output logic          ctl_osc_off,
  output logic          ctl_int_mode,
  output logic [1:0]    ctl_alm_ie,
  output logic [DW-1:0] trickle_cfg
);
  logic [2:0]    pin_now, pin_prev;
  logic          cs_q, sclk_rise, sclk_fall, mosi_q;
  logic [DW-1:0] rx_byte, rd_data;
  logic          byte_done, tx_bit;
  logic          first_q, is_wr_q, fetch_q;
  logic [AW-1:0] addr_q;
  logic          wr_go, rd_go;

  rtc_spi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({spi_cs, spi_sclk, spi_mosi}),
    .dout(pin_now), .dprev(pin_prev)
  );

  assign cs_q      = pin_now[2];
  assign sclk_rise = pin_now[1] && !pin_prev[1];
  assign sclk_fall = !pin_now[1] && pin_prev[1];
  assign mosi_q    = pin_now[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      fetch_q <= 1'b0;
    end else begin
      fetch_q <= 1'b0;
      if (!cs_q) begin
        first_q <= 1'b1;
        is_wr_q <= 1'b0;
      end else if (byte_done) begin
        if (first_q) begin
          addr_q  <= rx_byte[AW-1:0];
          is_wr_q <= rx_byte[DW-1];
          first_q <= 1'b0;
          fetch_q <= !rx_byte[DW-1];
        end else begin
          addr_q  <= addr_q + 1'b1;
          fetch_q <= !is_wr_q;
        end
      end
    end
  end

  assign wr_go = byte_done && cs_q && !first_q && is_wr_q;
  assign rd_go = fetch_q && cs_q;

  rtc_spi_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_q),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_bit(mosi_q),
    .tx_load(rd_go), .tx_data(rd_data),
    .rx_byte(rx_byte), .byte_done(byte_done), .tx_bit(tx_bit)
  );

  rtc_spi_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr_q), .wdata(rx_byte),
    .wr_go(wr_go), .rd_go(rd_go), .rd_data(rd_data),
    .reg_rd_stb(reg_rd_stb), .reg_wr_stb(reg_wr_stb),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alm_hit(alm_hit), .alm_flag(alm_flag),
    .ctl_osc_off(ctl_osc_off), .ctl_int_mode(ctl_int_mode),
    .ctl_alm_ie(ctl_alm_ie), .trickle_cfg(trickle_cfg)
  );

  assign spi_miso_oe = cs_q && !first_q && !is_wr_q;
  assign spi_miso    = spi_miso_oe && tx_bit;

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && cs_q && !first_q) |=> addr_q == $past(addr_q) + 1'b1);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_rd_stb, reg_wr_stb}));
endmodule

// File: tb/rtc_spi_regif_tb.sv
module rtc_spi_regif_tb_top;
  localparam int H = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe, reg_rd_stb, reg_wr_stb;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, trickle_cfg;
  logic [1:0] alm_hit = 2'b00, alm_flag, ctl_alm_ie;
  logic ctl_osc_off, ctl_int_mode;

  logic [7:0] tk [15];
  int wr_cnt = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_spi_regif dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs(spi_cs),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .reg_rd_stb(reg_rd_stb), .reg_wr_stb(reg_wr_stb), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alm_hit(alm_hit),
    .alm_flag(alm_flag), .ctl_osc_off(ctl_osc_off), .ctl_int_mode(ctl_int_mode),
    .ctl_alm_ie(ctl_alm_ie), .trickle_cfg(trickle_cfg)
  );

  // timekeeping model
  assign reg_rdata = (reg_addr <= 4'd14) ? tk[reg_addr] : 8'h00;
  always @(posedge clk) begin
    if (reg_wr_stb) begin
      if (reg_addr <= 4'd14) tk[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_start();
    @(negedge clk); spi_cs = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic spi_stop();
    repeat (H) @(negedge clk); spi_cs = 1'b0;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - n; i--) begin
      spi_sclk = 1'b1; spi_mosi = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b0;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r;
    spi_start(); spi_byte({1'b1, a}, r); spi_byte(d, r); spi_stop();
  endtask

  task automatic rd1(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] r;
    spi_start(); spi_byte({1'b0, a}, r); spi_byte(8'h00, d); spi_stop();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 osc_off", ctl_osc_off, 1);
    check("R1 flags", alm_flag, 0);
    check("R1 trickle", trickle_cfg, 8'h00);
    check("R1 miso_oe", spi_miso_oe, 0);
    rd1(7'h0F, d);
    check("R1 ctrl read", d, 8'hC0);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr1(7'h0F, 8'h00); rd1(7'h0F, d);
    check("R5 ctrl clear", d, 8'h00);
    check("R5 osc_off out", ctl_osc_off, 0);
    wr1(7'h0F, 8'hFF); rd1(7'h0F, d);
    check("R5 ctrl bits 5:3 zero", d, 8'hC7);
    check("R5 alm_ie out", ctl_alm_ie, 2'b11);
    check("R5 int_mode out", ctl_int_mode, 1);
    wr1(7'h0F, 8'h03); rd1(7'h0F, d);
    check("R6 ctrl writable under protect", d, 8'h03);
  endtask

  task automatic t_protect();
    logic [7:0] d;
    int c0;
    wr1(7'h20, 8'h11); wr1(7'h11, 8'h5A);
    wr1(7'h0F, 8'h43);
    c0 = wr_cnt;
    wr1(7'h20, 8'h55); wr1(7'h11, 8'hFF); wr1(7'h00, 8'h66);
    check("R6 no ext strobe", wr_cnt - c0, 0);
    check("R6 trickle kept", trickle_cfg, 8'h5A);
    rd1(7'h20, d);
    check("R6 ram kept", d, 8'h11);
    wr1(7'h0F, 8'h00);
  endtask

  task automatic t_burst_time();
    logic [7:0] r;
    spi_start(); spi_byte(8'h80, r);
    for (int i = 0; i < 7; i++) spi_byte(8'h30 + 8'(i), r);
    spi_stop();
    for (int i = 0; i < 7; i++) check("R4 ext write burst", tk[i], 8'h30 + 8'(i));
    spi_start(); spi_byte(8'h00, r);
    for (int i = 0; i < 7; i++) begin
      spi_byte(8'h00, r);
      check("R4 R2 ext read burst", r, 8'h30 + 8'(i));
    end
    spi_stop();
  endtask

  task automatic t_wrap();
    logic [7:0] r;
    spi_start(); spi_byte(8'hFE, r);
    spi_byte(8'hA1, r); spi_byte(8'hA2, r); spi_byte(8'hA3, r);
    spi_stop();
    check("R3 wrap to 0x00", tk[0], 8'hA3);
    spi_start(); spi_byte(8'h7E, r);
    spi_byte(8'h00, r); check("R9 ram 0x7E", r, 8'hA1);
    spi_byte(8'h00, r); check("R9 ram 0x7F", r, 8'hA2);
    spi_byte(8'h00, r); check("R3 read wrap", r, 8'hA3);
    spi_stop();
  endtask

  task automatic t_hole();
    logic [7:0] d;
    int c0;
    c0 = wr_cnt;
    wr1(7'h15, 8'h99); rd1(7'h15, d);
    check("R9 hole reads zero", d, 8'h00);
    check("R9 hole no strobe", wr_cnt - c0, 0);
    wr1(7'h11, 8'hA5); rd1(7'h11, d);
    check("R9 trickle read", d, 8'hA5);
    check("R9 trickle out", trickle_cfg, 8'hA5);
  endtask

  task automatic t_status();
    logic [7:0] d;
    @(negedge clk); alm_hit = 2'b01; @(negedge clk); alm_hit = 2'b00;
    rd1(7'h10, d);
    check("R7 status flag0", d, 8'h01);
    wr1(7'h10, 8'h00); rd1(7'h10, d);
    check("R7 status write ignored", d, 8'h01);
    rd1(7'h0B, d);
    check("R8 alarm1 read keeps flag0", alm_flag, 2'b01);
    rd1(7'h08, d);
    check("R8 alarm0 read clears", alm_flag, 2'b00);
  endtask

  task automatic t_collision();
    logic [7:0] r;
    @(negedge clk); alm_hit = 2'b10; @(negedge clk); alm_hit = 2'b00;
    check("R7 flag1 set", alm_flag, 2'b10);
    fork
      begin spi_start(); spi_byte(8'h0C, r); spi_stop(); end
      begin
        do @(negedge clk); while (!(reg_rd_stb && reg_addr == 4'hC));
        alm_hit = 2'b10; @(negedge clk); alm_hit = 2'b00;
      end
    join
    check("R8 hit wins over read clear", alm_flag, 2'b10);
    spi_start(); spi_byte(8'h0C, r); spi_stop();
    check("R8 alarm1 read clears", alm_flag, 2'b00);
  endtask

  task automatic t_abort();
    logic [7:0] r, d;
    wr1(7'h21, 8'h3C);
    spi_start(); spi_byte(8'hA1, r);
    check("R10 no oe on write", spi_miso_oe, 0);
    spi_bits(8'h77, 4, r);
    spi_stop();
    rd1(7'h21, d);
    check("R10 partial byte dropped", d, 8'h3C);
    spi_start(); spi_byte(8'h21, r);
    check("R10 oe during read", spi_miso_oe, 1);
    spi_byte(8'h00, r);
    check("R2 read data", r, 8'h3C);
    spi_stop();
    check("R10 oe off after cs", spi_miso_oe, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctrl();
    t_protect();
    t_burst_time();
    t_wrap();
    t_hole();
    t_status();
    t_collision();
    t_abort();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule